// File: doc/BRIEF.md
# Masked Change-of-State Interrupt Generator

This block watches a bank of already-synchronized port levels and drives one active-low interrupt line to a host. Every port keeps a reference copy of the level the host last acknowledged. A port raises its flag when its present level differs from that reference, its direction bit marks it as an input, and its mask bit leaves it enabled. All port flags are ORed together and registered once. The result drives the interrupt line, so the line cannot glitch.

The interrupt follows a level comparison and is not latched. It goes away by itself when the changed port returns to its acknowledged level. It also goes away when the register bank sends a one-cycle read pulse, which happens when the host reads the input register. That pulse copies every current port level into the references. Changes to the direction and mask bits take effect on the next clock and leave the references untouched. When several ports change, the host sees a single combined interrupt and gets no indication of which port changed.

Top module: `cos_irq_gen`

## Requirements
- R1: `irq_n` is 1 while `rst` is high and on the first clock after reset. During reset the references load the current port levels, so levels present at reset do not raise an interrupt.
- R2: `irq_n` goes to 0 one clock after a port meets all of these conditions: its level differs from its reference, its `dir_in` bit is 1 (1 = input), and its `irq_mask` bit is 0.
- R3: A port whose `dir_in` bit is 0 (0 = output) never pulls `irq_n` low, whatever its level does.
- R4: A port whose `irq_mask` bit is 1 (1 = masked) never pulls `irq_n` low.
- R5: If a changed port returns to its reference level before any read pulse, `irq_n` returns to 1 one clock later.
- R6: On a clock where `rd_ack` is 1, every reference loads its current port level. The `irq_n` value registered on that same clock still reflects the old references. From the next clock on, with the levels unchanged, `irq_n` is 1, and later changes are measured against the new references.
- R7: Changes on several ports give one combined interrupt. `irq_n` stays 0 until every contributing port matches its reference or is acknowledged.
- R8: A new mask or direction value takes effect on the next clock and does not alter the stored references. Unmasking a port that changed while it was masked therefore raises the interrupt.
- R9: When every port level equals its reference, `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | PORTS | Synchronized port levels |
| dir_in | input | PORTS | Direction per port, 1 = input, 0 = output |
| irq_mask | input | PORTS | Interrupt mask per port, 1 = masked |
| rd_ack | input | 1 | One-cycle pulse from a read of the input register |
| irq_n | output | 1 | Registered combined interrupt, active low |

## Verification
The hardest state to reach is a stale reference: the level of a masked or output port has moved away from its reference, and that mismatch must stay hidden until the port is unmasked or turned back into an input. The stimulus flips a port while it is masked, and later while it is configured as an output, and then releases only the gating bit. It checks that the interrupt appears without any pin activity. A second path acknowledges while the levels differ. It then moves a pin back to the old level and confirms that the interrupt now fires against the new reference.

// File: rtl/cos_pkg.sv
`timescale 1ns/1ps
package cos_pkg;
  // direction encoding of one port
  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} port_dir_e;

  // one port is live when it moved, is an input and is not masked
  function automatic logic port_live(input logic lvl, input logic held,
                                     input logic dir_b, input logic msk_b);
    return (lvl ^ held) & (port_dir_e'(dir_b) == DIR_IN) & ~msk_b;
  endfunction
endpackage

// File: rtl/cos_ref_bank.sv
`timescale 1ns/1ps
module cos_ref_bank #(
  parameter int PORTS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] pin_lvl,
  input  logic             rd_ack,
  output logic [PORTS-1:0] ref_lvl
);
  // per-port acknowledged level; reset and read pulse both capture the pin
  for (genvar g = 0; g < PORTS; g++) begin : g_ref
    always_ff @(posedge clk) begin
      if (rst || rd_ack) ref_lvl[g] <= pin_lvl[g];
    end
  end

  a_r6_ack_loads: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> ref_lvl == $past(pin_lvl));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |=> $stable(ref_lvl));
endmodule

// File: rtl/cos_flag_merge.sv
`timescale 1ns/1ps
module cos_flag_merge #(
  parameter int PORTS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] live,
  output logic             irq_n
);
  logic any_live;
  assign any_live = |live;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~any_live;
  end

  a_r2_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(any_live));
endmodule

// File: rtl/cos_irq_gen.sv
`timescale 1ns/1ps
module cos_irq_gen #(
  parameter int PORTS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] pin_lvl,
  input  logic [PORTS-1:0] dir_in,
  input  logic [PORTS-1:0] irq_mask,
  input  logic             rd_ack,
  output logic             irq_n
);
  import cos_pkg::*;

  logic [PORTS-1:0] ref_lvl;
  logic [PORTS-1:0] raw_diff;   // ungated mismatch, for assertions
  logic [PORTS-1:0] live;

  cos_ref_bank #(.PORTS(PORTS)) u_ref (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .rd_ack(rd_ack), .ref_lvl(ref_lvl)
  );

  assign raw_diff = pin_lvl ^ ref_lvl;

  for (genvar g = 0; g < PORTS; g++) begin : g_live
    assign live[g] = port_live(pin_lvl[g], ref_lvl[g], dir_in[g], irq_mask[g]);
  end

  cos_flag_merge #(.PORTS(PORTS)) u_merge (
    .clk(clk), .rst(rst), .live(live), .irq_n(irq_n)
  );

  a_r3_out_quiet: assert property (@(posedge clk) disable iff (rst)
    (dir_in == '0) |=> irq_n);
  a_r4_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '1) |=> irq_n);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    (raw_diff == '0) |=> irq_n);
endmodule

// File: tb/tb_cos_irq_gen.sv
`timescale 1ns/1ps
module tb_cos_irq_gen;
  localparam int PORTS = 16;

  typedef struct packed {
    logic [15:0] pins;
    logic [15:0] dir;
    logic [15:0] msk;
    logic        ack;
    logic        exp_n;
    logic [3:0]  req;
  } vec_t;

  // refs are 16'hA5A5 after reset
  localparam vec_t VEC [18] = '{
    '{16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd9}, // R9 idle
    '{16'hA5A4, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd2}, // R2 bit0 moved
    '{16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd5}, // R5 returned
    '{16'hA5A4, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 4'd4}, // R4 masked
    '{16'hA5A4, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd8}, // R8 unmask, ref kept
    '{16'hA5A4, 16'hFFFE, 16'h0000, 1'b0, 1'b1, 4'd3}, // R3 output port
    '{16'hA5A4, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd6}, // R6 ack edge, old refs
    '{16'hA5A4, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd6}, // R6 refs now A5A4
    '{16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd6}, // R6 old level now a change
    '{16'h25A5, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd7}, // R7 two ports
    '{16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd7}, // R7 one still differs
    '{16'hA5A4, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd7}, // R7 all back
    '{16'h5A5B, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 4'd4}, // R4 all masked
    '{16'h5A5B, 16'hFFFF, 16'h7FFF, 1'b0, 1'b0, 4'd8}, // R8 unmask bit15
    '{16'h5A5B, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 4'd6}, // R6 ack while masked
    '{16'h5A5B, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd6}, // R6 refs now 5A5B
    '{16'hA5A4, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd3}, // R3 all outputs
    '{16'hA5A4, 16'h0100, 16'h0000, 1'b0, 1'b0, 4'd8}  // R8 dir change next clock
  };

  logic clk = 1'b0;
  logic rst;
  logic [PORTS-1:0] pin_lvl, dir_in, irq_mask;
  logic rd_ack;
  logic irq_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cos_irq_gen #(.PORTS(PORTS)) dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .irq_mask(irq_mask), .rd_ack(rd_ack), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (irq_n !== exp) begin
      fails++;
      $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
    end
  endtask

  initial begin
    rst = 1'b1; pin_lvl = 16'hA5A5; dir_in = '1; irq_mask = '0; rd_ack = 1'b0;
    step(); step();
    check(1'b1, "R1 during reset");
    pin_lvl = 16'hA5A5;
    step();
    rst = 1'b0;
    step();
    check(1'b1, "R1 first clock after reset");
    for (int i = 0; i < 18; i++) begin
      pin_lvl = VEC[i].pins; dir_in = VEC[i].dir;
      irq_mask = VEC[i].msk; rd_ack = VEC[i].ack;
      step();
      rd_ack = 1'b0;
      checks++;
      if (irq_n !== VEC[i].exp_n) begin
        fails++;
        $display("FAIL R%0d row %0d irq_n actual=%b expected=%b",
                 VEC[i].req, i, irq_n, VEC[i].exp_n);
      end
    end
    // R1: reset while the interrupt is active, pins away from any old ref
    check(1'b0, "R8 before reset");
    rst = 1'b1; pin_lvl = 16'h1234; dir_in = '1; irq_mask = '0;
    step();
    check(1'b1, "R1 reset forces high");
    step();
    rst = 1'b0;
    step();
    check(1'b1, "R1 levels at reset not an interrupt");
    pin_lvl = 16'h1235;
    step();
    check(1'b0, "R2 change against reset capture");
    pin_lvl = 16'h1234;
    step();
    check(1'b1, "R5 back to captured level");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule